// File: doc/BRIEF.md
# Outbound Address Translation Window Table

This block sits between an on-chip memory-mapped request port and the outbound path toward a PCIe link. It holds a small programmable table of windows. Each window matches an incoming 32-bit address against a naturally aligned, power-of-two source range. On a hit the block keeps the in-window offset bits and swaps the bits above them for the window's translated base. It also tags the request as a configuration access or as a normal memory transfer, depending on a per-entry selector.

Configuration hits are screened before they leave. The in-window offset is decoded as bus, device/function and register offset. A request to the root bus may only reach device/function 0. A request to any other bus may only pass while the link-state input shows the link fully trained. A screened read completes locally with all ones and a screened write is dropped. Both complete without error. An address that hits no enabled window completes locally with a decode error. Software programs the table through a simple 32-bit register port with one-cycle read latency.

The controller handles one request at a time. A small state machine steps through idle, lookup, and one of three result states: forward, blocked or decode error.

Top module: `atw_bridge_xlate`

States and transitions:
- IDLE → LOOKUP when a request is accepted.
- LOOKUP → FORWARD on an allowed hit.
- LOOKUP → BLOCKED on a configuration hit that the filter rejects.
- LOOKUP → DECERR when no enabled entry hits.
- FORWARD, BLOCKED and DECERR each return to IDLE after one cycle.

## Requirements
- R1: After reset every entry is disabled: all table registers read 0, and any request ends in a decode error.
- R2: Entry i's registers sit at byte address 32*i plus an offset. Offset 0x0 holds the source word, 0x8 the translated base and 0x10 the route selector. In the source word, bit 0 is enable, bits [6:1] are the size field and bits [31:12] are the base; bits [11:7] read 0. Offsets 0x4 and 0xC read 0 and ignore writes. The route selector keeps bit 0 only. A register read returns its data one cycle after the read cycle.
- R3: A size field f selects a window of 2^(f+1) bytes, and f of 31 or more covers the whole space. An address hits when it matches the base in all bits at or above that size.
- R4: A forwarded address keeps the address bits below the window size and takes the bits above it from the translated base.
- R5: When several enabled entries hit, the lowest-numbered entry is used.
- R6: An address that hits no enabled entry produces a completion with the error flag set and data 0, and nothing is forwarded.
- R7: A hit forwards with the configuration tag equal to route selector bit 0 (1 = configuration, 0 = memory), and with the request's write flag.
- R8: For a configuration hit, the bus is taken from offset bits [27:20] and the device/function from bits [19:12]. On the root bus (0), any device/function other than 0 is blocked.
- R9: A configuration hit to a bus other than the root bus is forwarded only while link_state bit 4 is set, whatever the other bits are; otherwise it is blocked.
- R10: A blocked read completes without error and returns 0xFFFFFFFF. A blocked write completes without error with data 0 and is not forwarded.
- R11: req_ready is high only in the idle state. The single result (forward or completion) is valid during the second cycle after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | REG_AW | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid one cycle after the read |
| link_state | input | LINK_W | Link state; bit L0_BIT set means link trained |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | Request is a write |
| req_addr | input | 32 | Request address |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| fwd_valid | output | 1 | Translated request valid |
| fwd_addr | output | 32 | Translated address |
| fwd_cfg | output | 1 | 1 = configuration access, 0 = memory |
| fwd_write | output | 1 | Forwarded write flag |
| fwd_entry | output | IDX_W | Entry that produced the hit |
| cpl_valid | output | 1 | Local completion valid |
| cpl_err | output | 1 | Local completion is a decode error |
| cpl_data | output | 32 | Local completion read data |

## Verification
A corrupted state or a wrong lookup result shows at the ports on the second cycle after acceptance. It appears as the wrong result strobe, a wrong tag or a wrong address, and a stuck state shows as req_ready staying low. A damaged table register shows on the next read of that register, and on the next request that falls inside or just outside that window. Window edges on both sides, overlapping entries, and every branch of the configuration filter are each driven with a known expected outcome.

// File: rtl/atw_pkg.sv
package atw_pkg;

    localparam int DW = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_FORWARD,
        ST_BLOCKED,
        ST_DECERR
    } atw_state_e;

    localparam logic [4:0] OFF_SRC      = 5'h00;
    localparam logic [4:0] OFF_SRC_HI   = 5'h04;
    localparam logic [4:0] OFF_TRSL     = 5'h08;
    localparam logic [4:0] OFF_TRSL_HI  = 5'h0C;
    localparam logic [4:0] OFF_ROUTE    = 5'h10;

    // bits kept in a source word: base [31:12], size [6:1], enable [0]
    localparam logic [DW-1:0] SRC_KEEP = 32'hFFFF_F07F;

    // upper (compared) bits of a window whose size field is f
    function automatic logic [DW-1:0] win_mask(input logic [5:0] f);
        logic [6:0] n;
        n = {1'b0, f} + 7'd1;
        if (n >= 7'd32) return '0;
        return ~((32'd1 << n[4:0]) - 32'd1);
    endfunction

endpackage

// File: rtl/atw_regfile.sv
module atw_regfile
    import atw_pkg::*;
#(
    parameter int ENTRIES = 4,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int REG_AW = IDX_W + 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_sel,
    input  logic                       reg_we,
    input  logic [REG_AW-1:0]          reg_addr,
    input  logic [DW-1:0]              reg_wdata,
    output logic [DW-1:0]              reg_rdata,
    output logic [ENTRIES-1:0][DW-1:0] src_o,
    output logic [ENTRIES-1:0][DW-1:0] trsl_o,
    output logic [ENTRIES-1:0]         route_o
);

    logic [IDX_W-1:0] idx;
    logic [4:0]       off;
    logic             idx_ok;

    assign idx    = reg_addr[REG_AW-1:5];
    assign off    = reg_addr[4:0];
    assign idx_ok = (int'(idx) < ENTRIES);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        logic wr_here;
        assign wr_here = reg_sel && reg_we && idx_ok && (int'(idx) == g);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                src_o[g]   <= '0;
                trsl_o[g]  <= '0;
                route_o[g] <= 1'b0;
            end else if (wr_here) begin
                unique case (off)
                    OFF_SRC:   src_o[g]   <= reg_wdata & SRC_KEEP;
                    OFF_TRSL:  trsl_o[g]  <= reg_wdata;
                    OFF_ROUTE: route_o[g] <= reg_wdata[0];
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_sel && !reg_we) begin
            reg_rdata <= '0;
            if (idx_ok) begin
                unique case (off)
                    OFF_SRC:   reg_rdata <= src_o[idx];
                    OFF_TRSL:  reg_rdata <= trsl_o[idx];
                    OFF_ROUTE: reg_rdata <= {{(DW-1){1'b0}}, route_o[idx]};
                    default:   reg_rdata <= '0;
                endcase
            end
        end
    end

    // upper address words are not stored
    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && !reg_we && (off == OFF_SRC_HI || off == OFF_TRSL_HI))
            |=> (reg_rdata == '0));

endmodule

// File: rtl/atw_match.sv
module atw_match
    import atw_pkg::*;
#(
    parameter int ENTRIES = 4,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [DW-1:0]              addr,
    input  logic [ENTRIES-1:0][DW-1:0] src,
    input  logic [ENTRIES-1:0][DW-1:0] trsl,
    input  logic [ENTRIES-1:0]         route,
    output logic                       hit,
    output logic [IDX_W-1:0]           hit_idx,
    output logic                       hit_cfg,
    output logic [DW-1:0]              xaddr,
    output logic [DW-1:0]              offset
);

    logic [ENTRIES-1:0]         hit_vec;
    logic [ENTRIES-1:0][DW-1:0] mask;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        logic [DW-1:0] base;
        assign base       = {src[g][DW-1:12], 12'h000};
        assign mask[g]    = win_mask(src[g][6:1]);
        assign hit_vec[g] = src[g][0] && (((addr ^ base) & mask[g]) == '0);
    end

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
        hit_cfg = route[hit_idx];
        offset  = addr & ~mask[hit_idx];
        xaddr   = (trsl[hit_idx] & mask[hit_idx]) | offset;
    end

    always_comb begin
        if (hit) begin
            assert_keep_offset_R4: assert (((xaddr ^ addr) & ~win_mask(src[hit_idx][6:1])) == '0);
            assert_lowest_wins_R5: assert ((hit_vec & ((ENTRIES'(1) << hit_idx) - ENTRIES'(1))) == '0);
        end
    end

endmodule

// File: rtl/atw_cfg_filter.sv
module atw_cfg_filter
    import atw_pkg::*;
#(
    parameter int          LINK_W   = 8,
    parameter int          L0_BIT   = 4,
    parameter logic [7:0]  ROOT_BUS = 8'h00
) (
    input  logic [DW-1:0]     offset,
    input  logic              is_cfg,
    input  logic [LINK_W-1:0] link_state,
    output logic              allow
);

    logic [7:0] bus;
    logic [7:0] devfn;
    logic       on_root;

    assign bus     = offset[27:20];
    assign devfn   = offset[19:12];
    assign on_root = (bus == ROOT_BUS);

    always_comb begin
        if (!is_cfg)      allow = 1'b1;
        else if (on_root) allow = (devfn == 8'h00);
        else              allow = link_state[L0_BIT];
    end

endmodule

// File: rtl/atw_bridge_xlate.sv
module atw_bridge_xlate
    import atw_pkg::*;
#(
    parameter int          ENTRIES  = 4,
    parameter int          LINK_W   = 8,
    parameter int          L0_BIT   = 4,
    parameter logic [7:0]  ROOT_BUS = 8'h00,
    localparam int         IDX_W    = $clog2(ENTRIES),
    localparam int         REG_AW   = IDX_W + 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic [LINK_W-1:0] link_state,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [DW-1:0]     req_addr,
    output logic              req_ready,
    output logic              fwd_valid,
    output logic [DW-1:0]     fwd_addr,
    output logic              fwd_cfg,
    output logic              fwd_write,
    output logic [IDX_W-1:0]  fwd_entry,
    output logic              cpl_valid,
    output logic              cpl_err,
    output logic [DW-1:0]     cpl_data
);

    logic [ENTRIES-1:0][DW-1:0] tbl_src;
    logic [ENTRIES-1:0][DW-1:0] tbl_trsl;
    logic [ENTRIES-1:0]         tbl_route;

    atw_state_e state_q, state_d;

    logic [DW-1:0]    addr_q;
    logic             wr_q;
    logic [DW-1:0]    xaddr_q;
    logic             cfg_q;
    logic [IDX_W-1:0] idx_q;

    logic             m_hit;
    logic [IDX_W-1:0] m_idx;
    logic             m_cfg;
    logic [DW-1:0]    m_xaddr;
    logic [DW-1:0]    m_off;
    logic             f_allow;

    atw_regfile #(.ENTRIES(ENTRIES)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .src_o     (tbl_src),
        .trsl_o    (tbl_trsl),
        .route_o   (tbl_route)
    );

    atw_match #(.ENTRIES(ENTRIES)) u_match (
        .addr    (addr_q),
        .src     (tbl_src),
        .trsl    (tbl_trsl),
        .route   (tbl_route),
        .hit     (m_hit),
        .hit_idx (m_idx),
        .hit_cfg (m_cfg),
        .xaddr   (m_xaddr),
        .offset  (m_off)
    );

    atw_cfg_filter #(
        .LINK_W   (LINK_W),
        .L0_BIT   (L0_BIT),
        .ROOT_BUS (ROOT_BUS)
    ) u_filter (
        .offset     (m_off),
        .is_cfg     (m_cfg),
        .link_state (link_state),
        .allow      (f_allow)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid) state_d = ST_LOOKUP;
            ST_LOOKUP: begin
                if (!m_hit)        state_d = ST_DECERR;
                else if (!f_allow) state_d = ST_BLOCKED;
                else               state_d = ST_FORWARD;
            end
            ST_FORWARD: state_d = ST_IDLE;
            ST_BLOCKED: state_d = ST_IDLE;
            ST_DECERR:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // request and lookup capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wr_q    <= 1'b0;
            xaddr_q <= '0;
            cfg_q   <= 1'b0;
            idx_q   <= '0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                addr_q <= req_addr;
                wr_q   <= req_write;
            end
            if (state_q == ST_LOOKUP) begin
                xaddr_q <= m_xaddr;
                cfg_q   <= m_cfg;
                idx_q   <= m_idx;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        fwd_valid = 1'b0;
        cpl_valid = 1'b0;
        cpl_err   = 1'b0;
        cpl_data  = '0;
        unique case (state_q)
            ST_IDLE:    req_ready = 1'b1;
            ST_LOOKUP:  ;
            ST_FORWARD: fwd_valid = 1'b1;
            ST_BLOCKED: begin
                cpl_valid = 1'b1;
                cpl_data  = wr_q ? '0 : '1;
            end
            ST_DECERR: begin
                cpl_valid = 1'b1;
                cpl_err   = 1'b1;
            end
            default: ;
        endcase
        fwd_addr  = xaddr_q;
        fwd_cfg   = cfg_q;
        fwd_write = wr_q;
        fwd_entry = idx_q;
    end

    assert_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> ##2 (fwd_valid || cpl_valid));

    assert_miss_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP && !m_hit) |=> (cpl_valid && cpl_err && !fwd_valid));

    assert_link_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP && m_hit && m_cfg && !link_state[L0_BIT]
            && m_off[27:20] != ROOT_BUS) |=> !fwd_valid);

    assert_mem_tag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP && m_hit && !tbl_route[m_idx]) |=> (fwd_valid && !fwd_cfg));

endmodule

// File: tb/atw_bridge_xlate_test.sv
module atw_bridge_xlate_test;

    localparam int ENTRIES = 4;
    localparam int IDX_W   = 2;
    localparam int REG_AW  = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_sel = 1'b0, reg_we = 1'b0;
    logic [REG_AW-1:0] reg_addr = '0;
    logic [31:0]       reg_wdata = '0, reg_rdata;
    logic [7:0]        link_state = 8'h00;
    logic              req_valid = 1'b0, req_write = 1'b0;
    logic [31:0]       req_addr = '0;
    logic              req_ready, fwd_valid, fwd_cfg, fwd_write, cpl_valid, cpl_err;
    logic [31:0]       fwd_addr, cpl_data;
    logic [IDX_W-1:0]  fwd_entry;

    int tests = 0, fails = 0;

    always #2 clk = ~clk;  // 250 MHz

    atw_bridge_xlate #(.ENTRIES(ENTRIES)) uut (
        .clk(clk), .rst_n(rst_n),
        .reg_sel(reg_sel), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .link_state(link_state),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_ready(req_ready),
        .fwd_valid(fwd_valid), .fwd_addr(fwd_addr), .fwd_cfg(fwd_cfg),
        .fwd_write(fwd_write), .fwd_entry(fwd_entry),
        .cpl_valid(cpl_valid), .cpl_err(cpl_err), .cpl_data(cpl_data)
    );

    // kind: 0 forward, 1 local completion
    typedef struct {
        int          kind;
        logic [31:0] val;   // forward address or completion data
        logic        flag;  // forward cfg tag or completion error
        logic        wr;
        string       req;
    } exp_t;

    exp_t sb[$];

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops one expected item for every result strobe
    always @(negedge clk) begin
        if (rst_n && (fwd_valid || cpl_valid)) begin
            if (sb.size() == 0) begin
                check(1'b0, "R11 unexpected result", {fwd_valid, cpl_valid}, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (e.kind == 0) begin
                    check(fwd_valid && !cpl_valid, e.req, {cpl_valid, fwd_valid}, 32'h1);
                    check(fwd_addr == e.val, e.req, fwd_addr, e.val);
                    check(fwd_cfg == e.flag, e.req, fwd_cfg, e.flag);
                    check(fwd_write == e.wr, e.req, fwd_write, e.wr);
                end else begin
                    check(cpl_valid && !fwd_valid, e.req, {cpl_valid, fwd_valid}, 32'h2);
                    check(cpl_err == e.flag, e.req, cpl_err, e.flag);
                    check(cpl_data == e.val, e.req, cpl_data, e.val);
                end
            end
        end
    end

    task automatic reg_write(input logic [REG_AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_sel = 1'b0; reg_we = 1'b0;
    endtask

    task automatic reg_check(input logic [REG_AW-1:0] a, input logic [31:0] exp,
                             input string req);
        @(negedge clk);
        reg_sel = 1'b1; reg_we = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_sel = 1'b0;
        check(reg_rdata == exp, req, reg_rdata, exp);
    endtask

    task automatic send(input logic [31:0] a, input logic wr, input int kind,
                        input logic [31:0] val, input logic flag, input string req);
        exp_t e;
        e.kind = kind; e.val = val; e.flag = flag; e.wr = wr; e.req = req;
        @(negedge clk);
        check(req_ready, "R11 ready in idle", req_ready, 1);
        sb.push_back(e);
        req_valid = 1'b1; req_addr = a; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready && !fwd_valid && !cpl_valid, "R11 busy during lookup",
              {req_ready, fwd_valid, cpl_valid}, 0);
        @(negedge clk);   // result visible here, monitor compares
        @(negedge clk);
        check(sb.size() == 0, "R11 result within two cycles", sb.size(), 0);
        sb.delete();
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check(req_ready && !fwd_valid && !cpl_valid, "R1 idle after reset",
              {req_ready, fwd_valid, cpl_valid}, 32'h4);
        reg_check(7'h00, 32'h0, "R1 entry0 source");
        reg_check(7'h70, 32'h0, "R1 entry3 route");
        send(32'h0000_1000, 1'b0, 1, 32'h0, 1'b1, "R1 miss after reset");

        // program table
        reg_write(7'h00, 32'h4000_0037);  // 256 MB cfg window
        reg_write(7'h08, 32'h4000_0000);
        reg_write(7'h10, 32'h0000_0001);
        reg_write(7'h20, 32'h8000_001F);  // 64 KB mem window
        reg_write(7'h28, 32'h1234_0000);
        reg_write(7'h40, 32'h8000_0027);  // 1 MB mem window, overlaps entry1
        reg_write(7'h48, 32'hABC0_0000);
        reg_write(7'h60, 32'hFFFF_FFFF);
        reg_write(7'h64, 32'hDEAD_BEEF);
        reg_write(7'h70, 32'hFFFF_FFFE);

        // R2: register layout and readback
        reg_check(7'h20, 32'h8000_001F, "R2 entry1 source");
        reg_check(7'h60, 32'hFFFF_F07F, "R2 source reserved bits");
        reg_check(7'h64, 32'h0, "R2 upper source reads zero");
        reg_check(7'h6C, 32'h0, "R2 upper translated reads zero");
        reg_check(7'h70, 32'h0, "R2 route keeps bit0 only");
        reg_check(7'h10, 32'h1, "R2 entry0 route");
        reg_check(7'h48, 32'hABC0_0000, "R2 entry2 translated");
        reg_write(7'h60, 32'h9000_0026);  // entry3 disabled

        // R3 / R4 / R5: windows, translation, priority
        send(32'h8000_1234, 1'b0, 0, 32'h1234_1234, 1'b0, "R4 translate entry1");
        send(32'h8000_FFFC, 1'b0, 0, 32'h1234_FFFC, 1'b0, "R3 top of 64K window");
        send(32'h8001_0000, 1'b0, 0, 32'hABC1_0000, 1'b0, "R5 falls to entry2");
        send(32'h800F_FFF0, 1'b0, 0, 32'hABCF_FFF0, 1'b0, "R3 top of 1M window");
        send(32'h8010_0000, 1'b0, 1, 32'h0, 1'b1, "R3 past 1M window");
        send(32'h8000_0008, 1'b1, 0, 32'h1234_0008, 1'b0, "R7 memory write");

        // R6: disabled entry never hits
        send(32'h9000_0010, 1'b0, 1, 32'h0, 1'b1, "R6 disabled entry");

        // R7 / R8: configuration routing and root bus filtering
        send(32'h4000_0010, 1'b0, 0, 32'h4000_0010, 1'b1, "R8 root devfn0");
        send(32'h4000_1000, 1'b0, 1, 32'hFFFF_FFFF, 1'b0, "R10 blocked read");
        send(32'h4000_1000, 1'b1, 1, 32'h0, 1'b0, "R10 blocked write");

        // R9: link gating of non-root buses
        send(32'h4010_0000, 1'b0, 1, 32'hFFFF_FFFF, 1'b0, "R9 link down");
        link_state = 8'h10;
        send(32'h4010_0000, 1'b0, 0, 32'h4010_0000, 1'b1, "R9 link up");
        send(32'h4FF3_8004, 1'b1, 0, 32'h4FF3_8004, 1'b1, "R9 bus 255 write");
        send(32'h4000_8000, 1'b0, 1, 32'hFFFF_FFFF, 1'b0, "R8 root devfn8 link up");
        link_state = 8'hEF;
        send(32'h4020_0000, 1'b0, 1, 32'hFFFF_FFFF, 1'b0, "R9 bit4 clear");

        // R5 again with entry1 disabled
        reg_write(7'h20, 32'h8000_001E);
        send(32'h8000_1234, 1'b0, 0, 32'hABC0_1234, 1'b0, "R5 entry2 after disable");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule